// File: doc/BRIEF.md
# UART interrupt arbiter and identification

This block gathers the four interrupt causes of a serial port (line errors, received data or a character timeout, an empty transmit holding register, and a change on the modem inputs) and turns them into one active-high interrupt request and one identification byte for the host. Each cause is caught in a sticky pending flag. The flag is set by a one-cycle event from the datapath and dropped by the host access that services it. A four-bit enable register, held inside the block, masks which pending causes may be reported.

A small state machine records which cause is currently being reported. Its states are `ST_IDLE` (nothing to report), `ST_LINE`, `ST_RXD`, `ST_TXE` and `ST_MDM`. On every clock it moves from its present state to the state of the highest-priority cause that is both pending and enabled after that edge's sets and clears, and to `ST_IDLE` when no such cause exists. Every state can reach every other state in one step. The transmit-empty cause drops on a host read of the identification byte, but only if that read reported it.

Top module: `uart_irq_ident`

## Requirements
- R1: After a synchronous reset, `irq` is 0, `ier_rdata` is 0x00 and `iir` is 0x01 while `fifo_en` is 0.
- R2: A write to the enable register stores `ier_wdata[3:0]`. Bit 0 enables received data, bit 1 transmit empty, bit 2 line status and bit 3 modem status. `ier_rdata[7:4]` always read 0.
- R3: `iir[0]` is 0 exactly when at least one enabled cause is pending, and `irq` is its inverse.
- R4: `iir[2:1]` names the reported cause by priority: 11 line status (highest), 10 received data, 01 transmit empty, 00 modem status (lowest, also shown when nothing is pending).
- R5: Any bit of `ls_err` (overrun, parity, framing, break) sets the line-status cause, and `lsr_rd` clears it.
- R6: `rx_ready` or `rx_timeout` sets the received-data cause, and `rbr_rd` clears it. `iir[3]` is 1 only while received data is reported and a timeout has been seen since the last `rbr_rd`.
- R7: `tx_empty` sets the transmit-empty cause. `thr_wr` clears it. `iir_rd` clears it only when `iir[2:1]` read 01 with `iir[0]` 0 in that cycle; an `iir_rd` that reported a higher cause leaves it pending.
- R8: Any bit of `ms_delta` sets the modem-status cause, and `msr_rd` clears it.
- R9: A cause whose enable bit is 0 is never reported. It stays pending and is reported once its enable bit is set.
- R10: `iir[7:6]` both equal `fifo_en`, and `iir[5:4]` are always 0.
- R11: If a cause's set event and clear strobe arrive in the same cycle, the cause is pending afterwards.
- R12: An event or strobe sampled at a clock edge shows on `irq` and `iir` right after that edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register contents, upper nibble zero |
| ls_err | input | LS_W | Line error events: overrun, parity, framing, break |
| rx_ready | input | 1 | Received-data event |
| rx_timeout | input | 1 | Character timeout event |
| tx_empty | input | 1 | Transmit holding register emptied |
| ms_delta | input | MS_W | Modem input change events |
| fifo_en | input | 1 | FIFOs enabled, mirrored into the identification byte |
| iir_rd | input | 1 | Host read of the identification byte |
| lsr_rd | input | 1 | Host read of line status |
| rbr_rd | input | 1 | Host read of received data |
| msr_rd | input | 1 | Host read of modem status |
| thr_wr | input | 1 | Host write of transmit data |
| irq | output | 1 | Interrupt request, active high |
| iir | output | 8 | Identification byte |

## Verification
The bench builds the block with the default `LS_W` = 4 and `MS_W` = 4. With four causes and four enable bits, the full cross of enable masks and pending patterns is 256 cases, so it is swept completely. Each case is compared against a priority model computed in the bench, which covers every state and transition target of the reporting machine. Directed sequences add each error and modem bit on its own, the timeout flag, the conditional clear by an identification read, a set and clear in the same cycle, the FIFO-enabled bits, and the exact edge at which a change becomes visible.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NSRC     = 4;
    localparam int SRC_RXD  = 0;
    localparam int SRC_TXE  = 1;
    localparam int SRC_LINE = 2;
    localparam int SRC_MDM  = 3;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LINE = 3'd1,
        ST_RXD  = 3'd2,
        ST_TXE  = 3'd3,
        ST_MDM  = 3'd4
    } rep_e;

endpackage

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic d,
    output logic q
);

    // set has precedence over a clear arriving in the same cycle
    always_comb begin
        d = set | (q & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_d,
    output rep_e            state_q,
    output logic            irq,
    output logic [1:0]      id
);

    rep_e state_d;

    // next-state selection by fixed priority
    always_comb begin
        if (req_d[SRC_LINE]) begin
            state_d = ST_LINE;
        end else if (req_d[SRC_RXD]) begin
            state_d = ST_RXD;
        end else if (req_d[SRC_TXE]) begin
            state_d = ST_TXE;
        end else if (req_d[SRC_MDM]) begin
            state_d = ST_MDM;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        unique case (state_q)
            ST_LINE: begin irq = 1'b1; id = 2'b11; end
            ST_RXD:  begin irq = 1'b1; id = 2'b10; end
            ST_TXE:  begin irq = 1'b1; id = 2'b01; end
            ST_MDM:  begin irq = 1'b1; id = 2'b00; end
            ST_IDLE: begin irq = 1'b0; id = 2'b00; end
            default: begin irq = 1'b0; id = 2'b00; end
        endcase
    end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LS_W = 4,
    parameter int MS_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ier_wr,
    input  logic [7:0]      ier_wdata,
    output logic [7:0]      ier_rdata,
    input  logic [LS_W-1:0] ls_err,
    input  logic            rx_ready,
    input  logic            rx_timeout,
    input  logic            tx_empty,
    input  logic [MS_W-1:0] ms_delta,
    input  logic            fifo_en,
    input  logic            iir_rd,
    input  logic            lsr_rd,
    input  logic            rbr_rd,
    input  logic            msr_rd,
    input  logic            thr_wr,
    output logic            irq,
    output logic [7:0]      iir
);

    localparam int REG_W = 8;
    localparam int PAD_W = REG_W - NSRC;

    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] en_d;
    logic [NSRC-1:0] src_set;
    logic [NSRC-1:0] src_clr;
    logic [NSRC-1:0] pend_d;
    logic [NSRC-1:0] pend_q;
    logic            to_d;
    logic            to_q;
    logic [1:0]      id;
    logic            irq_int;
    rep_e            rep_q;

    // enable register
    always_comb begin
        en_d = ier_wr ? ier_wdata[NSRC-1:0] : en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign ier_rdata = {{PAD_W{1'b0}}, en_q};

    // cause events and service strobes
    always_comb begin
        src_set           = '0;
        src_clr           = '0;
        src_set[SRC_RXD]  = rx_ready | rx_timeout;
        src_clr[SRC_RXD]  = rbr_rd;
        src_set[SRC_TXE]  = tx_empty;
        src_clr[SRC_TXE]  = thr_wr | (iir_rd && (rep_q == ST_TXE));
        src_set[SRC_LINE] = |ls_err;
        src_clr[SRC_LINE] = lsr_rd;
        src_set[SRC_MDM]  = |ms_delta;
        src_clr[SRC_MDM]  = msr_rd;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        uart_irq_flag u_flag (
            .clk (clk),
            .rst (rst),
            .set (src_set[g]),
            .clr (src_clr[g]),
            .d   (pend_d[g]),
            .q   (pend_q[g])
        );
    end

    uart_irq_flag u_timeout (
        .clk (clk),
        .rst (rst),
        .set (rx_timeout),
        .clr (rbr_rd),
        .d   (to_d),
        .q   (to_q)
    );

    uart_irq_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .req_d   (pend_d & en_d),
        .state_q (rep_q),
        .irq     (irq_int),
        .id      (id)
    );

    assign irq = irq_int;
    assign iir = {fifo_en, fifo_en, 2'b00, (rep_q == ST_RXD) & to_q, id, ~irq_int};

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $past(rst) |-> (!irq && en_q == '0));

    // R3
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((pend_q & en_q) != '0));

    // R4
    line_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_q[SRC_LINE] && en_q[SRC_LINE]) |-> (iir[2:1] == 2'b11));

    // R5
    line_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && ls_err == '0) |=> !pend_q[SRC_LINE]);

    // R7
    txe_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && rep_q == ST_TXE && !tx_empty) |=> !pend_q[SRC_TXE]);

    // R7
    txe_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && rep_q == ST_LINE && pend_q[SRC_TXE] && !thr_wr) |=> pend_q[SRC_TXE]);

    // R9
    masked_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq);

    // R2
    ier_upper_zero_chk: assert property (@(posedge clk) ier_rdata[REG_W-1:NSRC] == '0);

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (msr_rd && ms_delta != '0) |=> pend_q[SRC_MDM]);

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       ier_wr;
    logic [7:0] ier_wdata;
    logic [7:0] ier_rdata;
    logic [3:0] ls_err;
    logic       rx_ready;
    logic       rx_timeout;
    logic       tx_empty;
    logic [3:0] ms_delta;
    logic       fifo_en;
    logic       iir_rd;
    logic       lsr_rd;
    logic       rbr_rd;
    logic       msr_rd;
    logic       thr_wr;
    logic       irq;
    logic [7:0] iir;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    uart_irq_ident u_dut (
        .clk(clk), .rst(rst), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
        .ls_err(ls_err), .rx_ready(rx_ready), .rx_timeout(rx_timeout), .tx_empty(tx_empty),
        .ms_delta(ms_delta), .fifo_en(fifo_en), .iir_rd(iir_rd), .lsr_rd(lsr_rd),
        .rbr_rd(rbr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr), .irq(irq), .iir(iir)
    );

    // priority model: index 0 rxd, 1 txe, 2 line, 3 modem
    function automatic logic [7:0] model(input logic [3:0] pend, input logic [3:0] en,
                                         input logic to, input logic fe);
        logic [3:0] m;
        logic [1:0] idc;
        logic       none;
        logic       tob;
        m    = pend & en;
        none = 1'b0;
        tob  = 1'b0;
        if (m[2])      idc = 2'b11;
        else if (m[0]) begin idc = 2'b10; tob = to; end
        else if (m[1]) idc = 2'b01;
        else if (m[3]) idc = 2'b00;
        else begin idc = 2'b00; none = 1'b1; end
        return {fe, fe, 2'b00, tob, idc, none};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk_iir(input string req, input logic [7:0] exp);
        chk(req, iir, exp);
        chk(req, {7'd0, irq}, {7'd0, ~exp[0]});
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs;
        ier_wr = 0; ier_wdata = 0; ls_err = 0; rx_ready = 0; rx_timeout = 0;
        tx_empty = 0; ms_delta = 0; iir_rd = 0; lsr_rd = 0; rbr_rd = 0;
        msr_rd = 0; thr_wr = 0;
    endtask

    task automatic do_reset;
        idle_inputs();
        rst = 1;
        tick();
        rst = 0;
    endtask

    task automatic set_ier(input logic [7:0] v);
        ier_wr = 1; ier_wdata = v;
        tick();
        ier_wr = 0; ier_wdata = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst = 1; fifo_en = 0;
        idle_inputs();
        tick();
        tick();
        rst = 0;
        // R1 reset state
        chk_iir("R1", 8'h01);
        chk("R1", ier_rdata, 8'h00);

        // R2 R3 R4 R9 exhaustive sweep of enables against pending sets
        for (int e = 0; e < 16; e++) begin
            for (int p = 0; p < 16; p++) begin
                do_reset();
                set_ier(8'hA0 | 8'(e));
                chk("R2", ier_rdata, 8'(e));
                rx_ready = p[0]; tx_empty = p[1];
                ls_err = p[2] ? 4'b0100 : 4'b0000;
                ms_delta = p[3] ? 4'b0010 : 4'b0000;
                tick();
                idle_inputs();
                chk_iir("R4", model(4'(p), 4'(e), 1'b0, 1'b0));
            end
        end

        // R5 each error flag alone
        for (int b = 0; b < 4; b++) begin
            do_reset();
            set_ier(8'h0F);
            ls_err = 4'(1 << b);
            tick();
            ls_err = 0;
            chk_iir("R5", 8'h06);
            lsr_rd = 1;
            tick();
            lsr_rd = 0;
            chk_iir("R5", 8'h01);
        end

        // R8 each modem delta alone
        for (int b = 0; b < 4; b++) begin
            do_reset();
            set_ier(8'h08);
            ms_delta = 4'(1 << b);
            tick();
            ms_delta = 0;
            chk_iir("R8", 8'h00);
            msr_rd = 1;
            tick();
            msr_rd = 0;
            chk_iir("R8", 8'h01);
        end

        // R6 timeout variant of received data
        do_reset();
        set_ier(8'h0F);
        rx_timeout = 1;
        tick();
        rx_timeout = 0;
        chk_iir("R6", 8'h0C);
        rbr_rd = 1;
        tick();
        rbr_rd = 0;
        chk_iir("R6", 8'h01);
        rx_ready = 1;
        tick();
        rx_ready = 0;
        chk_iir("R6", 8'h04);

        // R7 identification read clears transmit empty only when reported
        do_reset();
        set_ier(8'h07);
        tx_empty = 1; ls_err = 4'b0001;
        tick();
        idle_inputs();
        chk_iir("R7", 8'h06);
        iir_rd = 1;
        tick();
        iir_rd = 0;
        chk_iir("R7", 8'h06);
        lsr_rd = 1;
        tick();
        lsr_rd = 0;
        chk_iir("R7", 8'h02);
        iir_rd = 1;
        tick();
        iir_rd = 0;
        chk_iir("R7", 8'h01);
        tx_empty = 1;
        tick();
        tx_empty = 0;
        chk_iir("R7", 8'h02);
        thr_wr = 1;
        tick();
        thr_wr = 0;
        chk_iir("R7", 8'h01);

        // R9 masked cause kept, shown after enabling
        do_reset();
        rx_ready = 1;
        tick();
        rx_ready = 0;
        chk_iir("R9", 8'h01);
        set_ier(8'h01);
        chk_iir("R9", 8'h04);

        // R10 FIFO-enabled bits
        do_reset();
        fifo_en = 1;
        #1;
        chk_iir("R10", 8'hC1);
        fifo_en = 0;

        // R11 set and clear together
        do_reset();
        set_ier(8'h04);
        ls_err = 4'b1000;
        tick();
        ls_err = 4'b0010; lsr_rd = 1;
        tick();
        idle_inputs();
        chk_iir("R11", 8'h06);

        // R12 visible only after the sampling edge
        do_reset();
        set_ier(8'h08);
        ms_delta = 4'b0001;
        #2;
        chk_iir("R12", 8'h01);
        tick();
        ms_delta = 0;
        chk_iir("R12", 8'h00);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule